// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block sits between a byte-wide synchronous bus and a real-time clock counter block. The eight highest byte addresses of a 128K-byte space belong to the clock. Any other enabled access only raises a RAM-select output, and a separate memory serves that access. Software reads and writes the clock through a visible register bank, which is kept apart from the running counters.

Two control bits decide how the visible bank relates to the counters. The read-halt bit freezes the bank so that software sees a consistent snapshot while counting continues. The write-halt bit turns the bank into a staging area. Clearing it hands every staged byte to the counters in a single one-cycle load.

The block also substitutes a 512 Hz square wave into the seconds LSB when frequency test is on. While the power-fail input is high, it blocks every access.

Top module: `rtc_bus_front`

## Requirements
- R1: Addresses 0x1FFF8..0x1FFFF are clock registers, decoded by the low three address bits: 0 control, 1 seconds, 2 minutes, 3 hour, 4 day, 5 date, 6 month, 7 year. An enabled access to any lower address asserts `ram_sel`, and an access to a clock register keeps `ram_sel` low.
- R2: `dout_en` is high, and `dout` carries the addressed register, only when `cs_n`=0, `we_n`=1, `oe_n`=0, the address is a clock register and `pwr_fail`=0. Otherwise `dout` is 0.
- R3: While control bit 6 (read-halt) is 1, counter ticks do not change the visible registers.
- R4: With both halt bits 0, every `cnt_tick` copies `cnt_time` into the visible bank at that clock edge, so the new values are readable in the following cycle. After read-halt is cleared, the next tick refreshes all registers together.
- R5: While control bit 7 (write-halt) is 1, writes to registers 1..7 are stored in the bank and ticks are ignored. When a control write clears bit 7, `load_stb` is high for exactly the next cycle. During that cycle `load_time` holds the staged bytes: seconds in [7:0], minutes [15:8], hour [23:16], day [31:24], date [39:32], month [47:40], year [55:48].
- R6: With write-halt 0, writes to registers 1..7 have no effect.
- R7: Bits a register lacks are stored and read as 0. The kept bits are: seconds 0xFF, minutes 0x7F, hour 0x3F, day 0x47, date 0x3F, month 0x1F, year 0xFF.
- R8: Writes to control bits 5..0 are ignored, and those bits read as 0.
- R9: When day bit 6 (frequency test) is 1 and seconds bit 7 (oscillator stop) is 0, bit 0 of a seconds read equals the `sq_512` input. Otherwise it is the stored bit.
- R10: While `pwr_fail` is 1, `pfo_n` is 0, no write takes effect, and `dout_en` and `ram_sel` stay 0. `pfo_n` returns to 1 when `pwr_fail` falls.
- R11: After reset, all registers read 0, `load_stb` is 0 and `pfo_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| cs_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| dout | output | 8 | Read data, 0 when not driving |
| dout_en | output | 1 | Read data valid and driven |
| ram_sel | output | 1 | Access targets the memory below the clock |
| pwr_fail | input | 1 | Supply out of tolerance |
| pfo_n | output | 1 | Active-low power-fail indication |
| cnt_tick | input | 1 | Counter update pulse |
| cnt_time | input | 56 | Live counter bytes, same layout as `load_time` |
| sq_512 | input | 1 | 512 Hz square wave for frequency test |
| load_stb | output | 1 | One-cycle load of staged values into the counters |
| load_time | output | 56 | Staged register bytes |

## Verification
A wrong halt-bit state shows up on the next register read. A tick taken while the bank is frozen or staging, or one skipped while the bank is free, changes the read-back value in the cycle after the tick. A lost or doubled load appears on `load_stb` in the cycle right after the control write that clears write-halt. A stray stored bit that the mask should have cleared is visible at once when the register is read back, as is a frequency-test override applied under the wrong condition.

// File: rtl/rtc_bus_front.sv
module rtc_bus_front #(
  parameter int ADDR_W = 17,
  parameter int NREG   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          din,
  input  logic                cs_n,
  input  logic                oe_n,
  input  logic                we_n,
  output logic [7:0]          dout,
  output logic                dout_en,
  output logic                ram_sel,
  input  logic                pwr_fail,
  output logic                pfo_n,
  input  logic                cnt_tick,
  input  logic [NREG*8-1:0]   cnt_time,
  input  logic                sq_512,
  output logic                load_stb,
  output logic [NREG*8-1:0]   load_time
);
  localparam int TW = NREG * 8;
  localparam logic [TW-1:0] KEEP = 56'hFF_1F_3F_47_3F_7F_FF;
  localparam int DAY_FT = 3 * 8 + 6;
  localparam int SEC_OSC = 7;

  logic acc, clk_hit, wr;
  logic [2:0] idx;
  logic [5:0] lane;
  logic wbit_q, rbit_q, load_q;
  logic [TW-1:0] vis_q;
  logic [63:0] vis_x;
  logic [7:0] rd_byte;

  assign acc     = ~cs_n & ~pwr_fail;
  assign clk_hit = &addr[ADDR_W-1:3];
  assign idx     = addr[2:0];
  assign wr      = acc & ~we_n;
  assign ram_sel = acc & ~clk_hit;
  assign dout_en = acc & we_n & ~oe_n & clk_hit;
  assign pfo_n   = ~pwr_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbit_q <= 1'b0;
      rbit_q <= 1'b0;
      load_q <= 1'b0;
      vis_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (wr && clk_hit && idx == 3'd0) begin
        wbit_q <= din[7];
        rbit_q <= din[6];
        if (wbit_q && !din[7]) load_q <= 1'b1;
      end
      if (wbit_q) begin
        if (wr && clk_hit) begin
          for (int i = 1; i <= NREG; i++)
            if (idx == 3'(i))
              vis_q[(i-1)*8 +: 8] <= din & KEEP[(i-1)*8 +: 8];
        end
      end else if (!rbit_q && cnt_tick) begin
        vis_q <= cnt_time & KEEP;
      end
    end
  end

  assign vis_x = {{(64-TW){1'b0}}, vis_q};
  assign lane  = {idx - 3'd1, 3'b000};

  always_comb begin
    if (idx == 3'd0) rd_byte = {wbit_q, rbit_q, 6'b0};
    else             rd_byte = vis_x[lane +: 8];
    if (idx == 3'd1 && vis_q[DAY_FT] && !vis_q[SEC_OSC]) rd_byte[0] = sq_512;
  end

  assign dout      = dout_en ? rd_byte : 8'h00;
  assign load_stb  = load_q;
  assign load_time = vis_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit_q && !wbit_q) |=> $stable(vis_q));
  p_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wbit_q && !wr) |=> $stable(vis_q));
  p_strobe_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (!wbit_q && $past(wbit_q)));
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wbit_q && !cnt_tick) |=> $stable(vis_q));
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_q & ~KEEP) == '0);
  p_pfail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!pfo_n && !dout_en && !ram_sel));
endmodule

// File: tb/rtc_bus_front_bench.sv
module rtc_bus_front_bench;
  logic clk = 0, rst_n = 0;
  logic [16:0] addr = '0;
  logic [7:0] din = '0;
  logic cs_n = 1, oe_n = 1, we_n = 1, pwr_fail = 0, cnt_tick = 0, sq_512 = 0;
  logic [55:0] cnt_time = '0;
  logic [7:0] dout;
  logic dout_en, ram_sel, pfo_n, load_stb;
  logic [55:0] load_time;
  int checks = 0, fails = 0;
  logic [7:0] rv;
  logic ren, rram;

  localparam logic [16:0] CB = 17'h1FFF8;

  always #2.5 clk = ~clk;

  rtc_bus_front u_rtc_bus_front (.clk, .rst_n, .addr, .din, .cs_n, .oe_n, .we_n,
    .dout, .dout_en, .ram_sel, .pwr_fail, .pfo_n, .cnt_tick, .cnt_time, .sq_512,
    .load_stb, .load_time);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; cs_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); cs_n = 1; we_n = 1;
  endtask

  task automatic acc(logic [16:0] a, logic oe);
    @(negedge clk); addr = a; cs_n = 0; we_n = 1; oe_n = oe;
    #1 rv = dout; ren = dout_en; rram = ram_sel;
    cs_n = 1; oe_n = 1;
  endtask

  task automatic tick(logic [55:0] t);
    @(negedge clk); cnt_time = t; cnt_tick = 1;
    @(negedge clk); cnt_tick = 0;
  endtask

  task automatic t_reset;
    acc(CB, 0); chk("R11 ctrl", rv, 8'h00);
    acc(CB + 1, 0); chk("R11 sec", rv, 8'h00);
    chk("R11 load_stb", load_stb, 0);
    chk("R11 pfo_n", pfo_n, 1);
  endtask

  task automatic t_refresh;
    logic [55:0] t = 56'h24_12_31_07_23_59_58;
    tick(t);
    for (int i = 1; i <= 7; i++) begin
      acc(CB + 17'(i), 0);
      chk("R4 refresh byte", rv, t[(i-1)*8 +: 8]);
      chk("R1 dout_en on clock read", ren, 1);
      chk("R1 ram_sel low on clock", rram, 0);
    end
  endtask

  task automatic t_decode;
    acc(17'h1FFF7, 0);
    chk("R1 ram_sel below clock", rram, 1);
    chk("R2 no dout_en for ram", ren, 0);
    acc(CB + 7, 1);
    chk("R2 oe_n high no drive", ren, 0);
    chk("R2 dout zero", rv, 0);
  endtask

  task automatic t_freeze;
    wr(CB, 8'h40);
    acc(CB, 0); chk("R3 ctrl read bit", rv, 8'h40);
    tick(56'h25_01_01_01_00_00_00);
    acc(CB + 1, 0); chk("R3 frozen sec", rv, 8'h58);
    acc(CB + 7, 0); chk("R3 frozen year", rv, 8'h24);
    wr(CB, 8'h00);
    acc(CB + 1, 0); chk("R4 no refresh before tick", rv, 8'h58);
    tick(56'h25_01_01_01_00_00_00);
    acc(CB + 7, 0); chk("R4 year after release", rv, 8'h25);
    acc(CB + 1, 0); chk("R4 sec after release", rv, 8'h00);
  endtask

  task automatic t_stage;
    logic [55:0] s = 56'h99_06_15_03_12_45_30;
    wr(CB, 8'h80);
    for (int i = 1; i <= 7; i++) wr(CB + 17'(i), s[(i-1)*8 +: 8]);
    tick(56'h24_12_31_07_23_59_58);
    acc(CB + 2, 0); chk("R5 tick ignored while staging", rv, 8'h45);
    chk("R5 no load yet", load_stb, 0);
    @(negedge clk); addr = CB; din = 8'h00; cs_n = 0; we_n = 0;
    @(negedge clk); cs_n = 1; we_n = 1;
    #1 chk("R5 load_stb pulse", load_stb, 1);
    chk("R5 load_time", load_time, s);
    @(negedge clk); #1 chk("R5 load_stb single", load_stb, 0);
  endtask

  task automatic t_ignore;
    wr(CB + 2, 8'h11);
    acc(CB + 2, 0); chk("R6 write ignored", rv, 8'h45);
    wr(CB, 8'h3F);
    acc(CB, 0); chk("R8 ctrl low bits", rv, 8'h00);
  endtask

  task automatic t_masks_ft;
    wr(CB, 8'h80);
    wr(CB + 3, 8'hFF); acc(CB + 3, 0); chk("R7 hour mask", rv, 8'h3F);
    wr(CB + 6, 8'hFF); acc(CB + 6, 0); chk("R7 month mask", rv, 8'h1F);
    wr(CB + 4, 8'hFF); acc(CB + 4, 0); chk("R7 day mask", rv, 8'h47);
    sq_512 = 1; acc(CB + 1, 0); chk("R9 ft high", rv, 8'h31);
    sq_512 = 0; acc(CB + 1, 0); chk("R9 ft low", rv, 8'h30);
    wr(CB + 1, 8'hB0);
    sq_512 = 1; acc(CB + 1, 0); chk("R9 osc stopped", rv, 8'hB0);
    wr(CB + 4, 8'h03); wr(CB + 1, 8'h31);
    sq_512 = 0; acc(CB + 1, 0); chk("R9 ft off", rv, 8'h31);
    wr(CB, 8'h00);
  endtask

  task automatic t_pfail;
    @(negedge clk); pwr_fail = 1;
    #1 chk("R10 pfo_n low", pfo_n, 0);
    acc(CB, 0); chk("R10 no read", ren, 0);
    acc(17'h00100, 0); chk("R10 no ram_sel", rram, 0);
    wr(CB, 8'h80);
    @(negedge clk); pwr_fail = 0;
    #1 chk("R10 pfo_n back", pfo_n, 1);
    acc(CB, 0); chk("R10 write blocked", rv, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_refresh; t_decode; t_freeze; t_stage; t_ignore; t_masks_ft; t_pfail;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule